// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Generator

This block sits between a simple request/acknowledge local bus and a CompactFlash card that runs in True IDE mode. Each local request becomes one timed PIO read or write on the ATA pins. The block decodes which register block the access targets and drives the two chip selects and the three register address lines. It produces the read or write strobe, the chip-select envelope and the data-bus enable from clock counts that software programs for the selected PIO mode. It also stretches the strobe while the device reports not-ready, and it returns read data captured on the last clock of the strobe.

Software turns nanosecond timings into clock counts and writes them through a configuration port. The block adds one setup clock to guard against ringing, and it enforces at least two clocks of recovery. A new configuration applies at the start of the next access and never changes an access in progress. Register accesses are 8 bits wide and always travel on data bits [7:0]. Data-port accesses are 16 bits wide.

Top module: `pata_pio_engine`

## Requirements
- R1: During and after reset, both chip selects, both strobes and the data enable are inactive (high, high, high, high, low), `ack` is low and `rdata` is zero.
- R2: Local address bit 21 picks the register block. 0 selects the command block, which drives `ide_cs0_n` low and keeps `ide_cs1_n` high. 1 selects the control block, which drives `ide_cs1_n` low and keeps `ide_cs0_n` high.
- R3: `ide_da[2:0]` equals local address bits [3:1] whenever a chip select is low. The control/alternate-status register is index 6, which is local byte offset 0x0C.
- R4: With programmed setup s and pulse p, the strobe goes low on clock s+1 of the access, counting the clock after acceptance as clock 0. It stays low for p clocks, and a p of 0 acts as 1.
- R5: The access lasts C = max(programmed cycle, (s+1)+p+2) clocks, so recovery after the strobe is never shorter than two clocks.
- R6: The selected chip select is low from clock 1 for exactly C-2 clocks, and the strobe lies inside that window.
- R7: A write (`rnw`=0) uses the same timing on `ide_diow_n` with `ide_dior_n` held high. `ide_dd_oe` is high exactly while the chip select is low. `ide_dd_out` carries `wdata` for a 16-bit access (`wide`=1) and {8'h00, `wdata[7:0]`} for an 8-bit access.
- R8: A read captures `ide_dd_in` on the last strobe clock. `rdata` shows all 16 bits for a 16-bit access and {8'h00, `ide_dd_in[7:0]`} for an 8-bit access.
- R9: Each clock that `ide_iordy` is low on the last pulse clock lengthens the strobe and the whole access by one clock.
- R10: `ack` is high for exactly one clock, on the last clock of the access. A request that is still held while the engine is busy starts nothing further.
- R11: Values written on the configuration port do not change an access in progress. They govern the next access.
- R12: After reset the programmed timing is setup 7, pulse 29 and cycle 60, which is PIO mode 0 at a 10 ns clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, accepted when idle |
| addr | input | ADDR_W | Local byte address |
| rnw | input | 1 | 1 = read, 0 = write |
| wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit register access |
| wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data of the last read |
| cfg_we | input | 1 | Timing register write enable |
| cfg_setup | input | 8 | Programmed strobe setup clocks |
| cfg_pulse | input | 8 | Programmed strobe pulse clocks |
| cfg_cycle | input | 8 | Programmed total cycle clocks |
| ide_cs0_n | output | 1 | Command-block chip select, active low |
| ide_cs1_n | output | 1 | Control-block chip select, active low |
| ide_da | output | 3 | Device register address |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Data driven to the device |
| ide_dd_oe | output | 1 | Data bus output enable |
| ide_dd_in | input | 16 | Data from the device |
| ide_iordy | input | 1 | Device ready, low = extend pulse |

## Verification
The hardest case to reach is a wait extension that lands exactly on the last pulse clock. The bench holds `ide_iordy` low from the start of the access. It counts strobe clocks at the pins and releases ready only after p plus the chosen wait count. This puts the extra clocks precisely at the hold point. A timing-register write issued a few clocks into a long access shows that the new values apply only to the following access. Programmed cycles just below, at and above setup+pulse+2 probe the recovery stretch.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
        cnt_t cycle;
    } timing_t;

    typedef enum logic {
        BLK_CMD = 1'b0,
        BLK_CTL = 1'b1
    } blk_e;

    typedef struct packed {
        blk_e       blk;
        logic [2:0] da;
    } ide_sel_t;

    // Programmed counts -> counts the engine runs with
    function automatic timing_t derive_timing(timing_t prog);
        timing_t eff;
        cnt_t    min_cyc;
        eff.setup = prog.setup + cnt_t'(1);
        eff.pulse = (prog.pulse == '0) ? cnt_t'(1) : prog.pulse;
        min_cyc   = eff.setup + eff.pulse + cnt_t'(2);
        eff.cycle = (prog.cycle < min_cyc) ? min_cyc : prog.cycle;
        return eff;
    endfunction

endpackage

// File: rtl/pata_addr_decode.sv
module pata_addr_decode
    import pata_pio_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int BLK_BIT = 21
) (
    input  logic [ADDR_W-1:0] addr,
    output ide_sel_t          sel
);
    always_comb begin
        sel.blk = addr[BLK_BIT] ? BLK_CTL : BLK_CMD;
        sel.da  = addr[3:1];
    end
endmodule

// File: rtl/pata_timing_regs.sv
module pata_timing_regs
    import pata_pio_pkg::*;
#(
    parameter int DEF_SETUP = 7,
    parameter int DEF_PULSE = 29,
    parameter int DEF_CYCLE = 60
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  timing_t wr_val,
    output timing_t eff
);
    timing_t prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q.setup <= cnt_t'(DEF_SETUP);
            prog_q.pulse <= cnt_t'(DEF_PULSE);
            prog_q.cycle <= cnt_t'(DEF_CYCLE);
        end else if (we) begin
            prog_q <= wr_val;
        end
    end

    assign eff = derive_timing(prog_q);
endmodule

// File: rtl/pata_cycle_timer.sv
module pata_cycle_timer
    import pata_pio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t tim_in,
    input  logic    ready,
    output logic    busy,
    output logic    cs_win,
    output logic    strobe,
    output logic    sample,
    output logic    done
);
    cnt_t    cnt_q;
    timing_t tim_q;
    cnt_t    strobe_end;
    cnt_t    cs_last;
    logic    last_pulse;
    logic    hold;

    always_comb begin
        strobe_end = tim_q.setup + tim_q.pulse;
        cs_last    = tim_q.cycle - cnt_t'(2);
        strobe     = busy && (cnt_q >= tim_q.setup) && (cnt_q < strobe_end);
        last_pulse = strobe && (cnt_q == strobe_end - cnt_t'(1));
        hold       = last_pulse && !ready;
        sample     = last_pulse && ready;
        cs_win     = busy && (cnt_q >= cnt_t'(1)) && (cnt_q <= cs_last);
        done       = busy && (cnt_q == tim_q.cycle - cnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            tim_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
                tim_q <= tim_in;
            end
        end else if (done) begin
            busy  <= 1'b0;
        end else if (!hold) begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BLK_BIT   = 21,
    parameter int DEF_SETUP = 7,
    parameter int DEF_PULSE = 29,
    parameter int DEF_CYCLE = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              wide,
    input  logic [15:0]       wdata,
    output logic              ack,
    output logic [15:0]       rdata,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_cycle,
    output logic              ide_cs0_n,
    output logic              ide_cs1_n,
    output logic [2:0]        ide_da,
    output logic              ide_dior_n,
    output logic              ide_diow_n,
    output logic [15:0]       ide_dd_out,
    output logic              ide_dd_oe,
    input  logic [15:0]       ide_dd_in,
    input  logic              ide_iordy
);
    ide_sel_t   sel_in, sel_q;
    timing_t    eff_tim;
    logic       busy, cs_win, strobe, sample, done, start;
    logic       rnw_q, wide_q;
    logic [15:0] wdata_q;

    pata_addr_decode #(.ADDR_W(ADDR_W), .BLK_BIT(BLK_BIT)) u_dec (
        .addr (addr),
        .sel  (sel_in)
    );

    pata_timing_regs #(
        .DEF_SETUP(DEF_SETUP), .DEF_PULSE(DEF_PULSE), .DEF_CYCLE(DEF_CYCLE)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wr_val ('{setup: cfg_setup, pulse: cfg_pulse, cycle: cfg_cycle}),
        .eff    (eff_tim)
    );

    assign start = req && !busy;

    pata_cycle_timer u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tim_in (eff_tim),
        .ready  (ide_iordy),
        .busy   (busy),
        .cs_win (cs_win),
        .strobe (strobe),
        .sample (sample),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '{blk: BLK_CMD, da: 3'd0};
            rnw_q   <= 1'b1;
            wide_q  <= 1'b0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (start) begin
                sel_q   <= sel_in;
                rnw_q   <= rnw;
                wide_q  <= wide;
                wdata_q <= wdata;
            end
            if (sample && rnw_q) begin
                rdata <= wide_q ? ide_dd_in : {8'h00, ide_dd_in[7:0]};
            end
        end
    end

    always_comb begin
        ide_cs0_n  = !(cs_win && sel_q.blk == BLK_CMD);
        ide_cs1_n  = !(cs_win && sel_q.blk == BLK_CTL);
        ide_da     = sel_q.da;
        ide_dior_n = !(strobe && rnw_q);
        ide_diow_n = !(strobe && !rnw_q);
        ide_dd_oe  = cs_win && !rnw_q;
        ide_dd_out = wide_q ? wdata_q : {8'h00, wdata_q[7:0]};
        ack        = done;
    end
endmodule

// File: rtl/pata_pio_checks.sv
module pata_pio_checks (
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic       ide_cs0_n,
    input logic       ide_cs1_n,
    input logic [2:0] ide_da,
    input logic       ide_dior_n,
    input logic       ide_diow_n,
    input logic       ide_dd_oe
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && !ide_dd_oe && !ack)); // R1

    AST_ONE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !(!ide_cs0_n && !ide_cs1_n)); // R2

    AST_DA_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((!ide_cs0_n || !ide_cs1_n) && $past(!ide_cs0_n || !ide_cs1_n)) |-> $stable(ide_da)); // R3

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (!ide_dior_n || !ide_diow_n) |-> (!ide_cs0_n || !ide_cs1_n)); // R6

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!ide_dior_n && !ide_diow_n)); // R7

    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        ide_dd_oe |-> ide_dior_n); // R7

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R10
endmodule

bind pata_pio_engine pata_pio_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .ide_cs0_n  (ide_cs0_n),
    .ide_cs1_n  (ide_cs1_n),
    .ide_da     (ide_da),
    .ide_dior_n (ide_dior_n),
    .ide_diow_n (ide_diow_n),
    .ide_dd_oe  (ide_dd_oe)
);

// File: tb/sim_pata_pio_engine.sv
module sim_pata_pio_engine;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       rnw;
        logic       wide;
        logic       blk;
        logic [2:0] rg;
        logic [7:0] su;
        logic [7:0] pw;
        logic [7:0] cy;
        logic [15:0] d;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 3'd0, 8'd7, 8'd29, 8'd60, 16'hA55A},
        '{1'b0, 1'b0, 1'b0, 3'd7, 8'd2, 8'd3,  8'd4,  16'h1234},
        '{1'b1, 1'b0, 1'b1, 3'd6, 8'd1, 8'd4,  8'd20, 16'hC3F0},
        '{1'b0, 1'b1, 1'b0, 3'd0, 8'd0, 8'd0,  8'd0,  16'h5AA5},
        '{1'b1, 1'b0, 1'b0, 3'd3, 8'd3, 8'd5,  8'd11, 16'h7E81},
        '{1'b1, 1'b0, 1'b0, 3'd3, 8'd3, 8'd5,  8'd10, 16'h0F0F},
        '{1'b0, 1'b0, 1'b1, 3'd6, 8'd4, 8'd6,  8'd30, 16'hFF00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic        rnw = 1'b1;
    logic        wide = 1'b0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_setup = '0, cfg_pulse = '0, cfg_cycle = '0;
    logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dd_oe;
    logic [2:0]  ide_da;
    logic [15:0] ide_dd_out;
    logic [15:0] ide_dd_in = '0;
    logic        ide_iordy = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    // measurement results
    int s_first, s_len, cs_first, cs_len, oe_len, total, acks, cs_extra;
    bit cs_bad, da_bad, other_bad, oe_bad, dat_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    pata_pio_engine u0 (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .rnw(rnw), .wide(wide),
        .wdata(wdata), .ack(ack), .rdata(rdata), .cfg_we(cfg_we),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
        .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_da(ide_da),
        .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
        .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe),
        .ide_dd_in(ide_dd_in), .ide_iordy(ide_iordy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [7:0] s, input logic [7:0] p, input logic [7:0] c);
        @(negedge clk);
        cfg_setup = s; cfg_pulse = p; cfg_cycle = c; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; p_exp is the expected pulse (for ready release)
    task automatic access(input logic r, input logic w, input logic b,
                          input logic [2:0] rg, input logic [15:0] d,
                          input int p_exp, input int wait_n,
                          input bit hold_req, input bit cfg_mid);
        bit   fin;
        bit   strb, oth, csl, csx;
        int   sc;
        logic [15:0] expw;
        expw = w ? d : {8'h00, d[7:0]};
        s_first = -1; s_len = 0; cs_first = -1; cs_len = 0; oe_len = 0;
        total = 0; acks = 0; cs_extra = 0;
        cs_bad = 0; da_bad = 0; other_bad = 0; oe_bad = 0; dat_bad = 0;
        sc = 0; fin = 0;
        @(negedge clk);
        addr = (b ? 24'hE00000 : 24'hC00000) | (24'(rg) << 1);
        rnw = r; wide = w; wdata = d; ide_dd_in = d;
        ide_iordy = (wait_n == 0);
        req = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 1000 && !fin; k++) begin
            @(negedge clk);
            if (k == 0 && !hold_req) req = 1'b0;
            if (cfg_mid && k == 3) begin
                cfg_setup = 8'd5; cfg_pulse = 8'd5; cfg_cycle = 8'd40; cfg_we = 1'b1;
            end
            if (cfg_mid && k == 4) cfg_we = 1'b0;
            strb = r ? !ide_dior_n : !ide_diow_n;
            oth  = r ? !ide_diow_n : !ide_dior_n;
            csl  = b ? !ide_cs1_n : !ide_cs0_n;
            csx  = b ? !ide_cs0_n : !ide_cs1_n;
            if (strb) begin
                if (s_first < 0) s_first = k;
                s_len++;
                sc++;
                if (sc == p_exp + wait_n) ide_iordy = 1'b1;
            end
            if (oth) other_bad = 1;
            if (csl) begin
                if (cs_first < 0) cs_first = k;
                cs_len++;
                if (ide_da != rg) da_bad = 1;
            end
            if (csx) cs_bad = 1;
            if (ide_dd_oe) begin
                oe_len++;
                if (r || !csl) oe_bad = 1;
                else if (ide_dd_out != expw) dat_bad = 1;
            end
            if (ack) begin
                acks++;
                total = k + 1;
                fin = 1;
                req = 1'b0;
            end
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ack) acks++;
            if (!ide_cs0_n || !ide_cs1_n) cs_extra++;
        end
        ide_iordy = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 cs0_n", ide_cs0_n, 1);
        chk("R1 cs1_n", ide_cs1_n, 1);
        chk("R1 dior_n/diow_n", {ide_dior_n, ide_diow_n}, 3);
        chk("R1 ack/oe", {ack, ide_dd_oe}, 0);
        chk("R1 rdata", rdata, 0);
        rst = 1'b0;

        // R12: default timing (S=8, P=29, C=60)
        access(1'b1, 1'b1, 1'b0, 3'd1, 16'hBEEF, 29, 0, 0, 0);
        chk("R12 strobe start", s_first, 8);
        chk("R12 strobe len", s_len, 29);
        chk("R12 total", total, 60);
        chk("R12 rdata", rdata, 16'hBEEF);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            int se, pe, ce;
            vec_t v;
            v = VECS[i];
            se = int'(v.su) + 1;
            pe = (v.pw == 0) ? 1 : int'(v.pw);
            ce = (int'(v.cy) < se + pe + 2) ? se + pe + 2 : int'(v.cy);
            set_cfg(v.su, v.pw, v.cy);
            access(v.rnw, v.wide, v.blk, v.rg, v.d, pe, 0, 0, 0);
            chk($sformatf("R4 vec%0d strobe start", i), s_first, se);
            chk($sformatf("R4 vec%0d strobe len", i), s_len, pe);
            chk($sformatf("R5 vec%0d total", i), total, ce);
            chk($sformatf("R6 vec%0d cs start", i), cs_first, 1);
            chk($sformatf("R6 vec%0d cs len", i), cs_len, ce - 2);
            chk($sformatf("R2 vec%0d wrong block", i), int'(cs_bad), 0);
            chk($sformatf("R3 vec%0d da", i), int'(da_bad), 0);
            chk($sformatf("R7 vec%0d other strobe", i), int'(other_bad), 0);
            if (v.rnw) begin
                chk($sformatf("R8 vec%0d rdata", i), rdata,
                    v.wide ? v.d : {8'h00, v.d[7:0]});
                chk($sformatf("R7 vec%0d oe on read", i), oe_len, 0);
            end else begin
                chk($sformatf("R7 vec%0d oe len", i), oe_len, ce - 2);
                chk($sformatf("R7 vec%0d wdata", i), int'(oe_bad | dat_bad), 0);
            end
        end

        // R9: ready held low adds 4 clocks (S=3,P=3,C=12)
        set_cfg(8'd2, 8'd3, 8'd12);
        access(1'b1, 1'b0, 1'b0, 3'd2, 16'h0066, 3, 4, 0, 0);
        chk("R9 strobe len", s_len, 7);
        chk("R9 total", total, 16);
        chk("R9 rdata", rdata, 16'h0066);

        // R10: request held during busy -> one ack, no second cycle
        access(1'b0, 1'b1, 1'b0, 3'd0, 16'h3C3C, 3, 0, 1, 0);
        chk("R10 ack count", acks, 1);
        chk("R10 no restart", cs_extra, 0);
        chk("R10 total", total, 12);

        // R11: config change mid-access (S=2,P=2,C=10 -> S=6,P=5,C=40)
        set_cfg(8'd1, 8'd2, 8'd10);
        access(1'b1, 1'b0, 1'b0, 3'd4, 16'h0011, 2, 0, 0, 1);
        chk("R11 current total", total, 10);
        chk("R11 current strobe start", s_first, 2);
        access(1'b1, 1'b0, 1'b0, 3'd4, 16'h0022, 5, 0, 0, 0);
        chk("R11 next total", total, 40);
        chk("R11 next strobe start", s_first, 6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule